// File: doc/BRIEF.md
# Host Bridge Register Window Decoder

This block sits on the processor side of a PCI host bridge and decodes a 16 MB register aperture. Every request on a simple request/response bus is steered to one destination. Offsets below 0xC00000 go to an I/O window. Fixed offsets higher up hold a configuration address register, a configuration data port and an interrupt-acknowledge read. Any other offset reads as all ones. Requests carry a dword address and byte enables, so accesses of one to four bytes are supported in little-endian lane order.

Configuration data accesses aimed at bus 0, device 0, function 0 are answered inside the block by the bridge's own host function. That function reports its identity and holds two registers that place a 4-byte GPIO sub-window inside the I/O window. The first register stores a base offset. The second arms the mapping only when the value 0x11 is written to it. Configuration accesses to any other target are forwarded on a configuration request port. Interrupt acknowledge is forwarded on a one-signal request port that returns an 8-bit vector.

The block accepts one request per cycle and answers each request one cycle later.

Top module: `hostwin_decoder`

## Requirements
- R1: After reset, `rspValid` is low, the configuration address register reads 0, and the GPIO sub-window is not mapped, so every I/O offset goes to the I/O port.
- R2: A request at an offset below 0xC00000 asserts `ioValid` in the same cycle with `ioAddr` equal to the request offset. A read returns `ioRdata`. This I/O window takes priority over every other decode.
- R3: Offset 0xC00CF8 is the configuration address register. A write updates only the enabled byte lanes, and a read returns the whole register.
- R4: Offsets 0xE00CFC–0xE00CFF form the configuration data port. Lanes are selected by `reqBe`, where lane n is offset +n and data bits [8n+7:8n]. With address bit 31 set and address bits [23:8] not all zero, the access is forwarded on `cfgValid`, with `cfgAddr` equal to the address register and the lanes passed through unchanged.
- R5: While address bit 31 is clear, configuration data reads return 0xFFFFFFFF, writes change nothing, and `cfgValid` stays low.
- R6: A read at 0xF00000 pulses `intaValid` in the same cycle and returns `{24'h0, intaVector}`. A write there is dropped and does not pulse `intaValid`.
- R7: Reads at any other offset at or above 0xC00000 return 0xFFFFFFFF. Writes there change no register and drive no port valid.
- R8: With bit 31 set and bits [23:8] zero, configuration data reads go to the host function: register 0x00 reads 0x066010CC (device 0x0660, vendor 0x10CC), register 0x08 reads 0x06000000 (host-bridge class, revision 0), and unlisted registers read 0.
- R9: Host-function register 0x40 holds the GPIO base offset. Only bits [23:2] are kept; the other bits read as 0.
- R10: Writing a value to host-function register 0x44 that equals exactly 0x00000011, counting disabled lanes as zero, maps the GPIO window at the dword (current base + 0x38). Accesses to that dword then go to `gpioValid`/`gpioRdata` instead of the I/O port. A later mapping replaces the earlier one. Other values, and base changes alone, leave the mapping unchanged.
- R11: Every request produces exactly one `rspValid` pulse in the following cycle. Write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Byte offset in the aperture; bits [1:0] are passed only to the I/O port |
| reqBe | input | 4 | Byte lane enables |
| reqWdata | input | 32 | Write data, little-endian lanes |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspRdata | output | 32 | Read data (0 for writes) |
| fwdWrite | output | 1 | Direction for the forwarded request |
| fwdBe | output | 4 | Lane enables for the forwarded request |
| fwdWdata | output | 32 | Write data for the forwarded request |
| ioValid | output | 1 | I/O window access |
| ioAddr | output | 24 | Offset inside the I/O window |
| ioRdata | input | 32 | I/O window read data, same cycle |
| gpioValid | output | 1 | GPIO sub-window access |
| gpioRdata | input | 32 | GPIO read data, same cycle |
| cfgValid | output | 1 | Forwarded configuration data access |
| cfgAddr | output | 32 | Current configuration address register |
| cfgRdata | input | 32 | Configuration read data, same cycle |
| intaValid | output | 1 | Interrupt-acknowledge request |
| intaVector | input | 8 | Vector returned by the acknowledge |

## Verification
Assertions check on every cycle that at most one destination is selected and that every request is answered exactly one cycle later. They also check that an armed GPIO window never disappears, that a non-key write to the enable register leaves the window where it was, and that dropped writes leave the registers untouched. Only the bench scenarios can show the rest: the actual decode map across the aperture, the returned data values, the host-function identity, and the relocation of the GPIO window after a new base is followed by a key write.

// File: rtl/hostwin_pkg.sv
package hostwin_pkg;

  // One-hot destination selection plus direction, from control to datapath.
  typedef struct packed {
    logic io;
    logic gpio;
    logic cfgAddr;
    logic cfgExt;
    logic cfgInt;
    logic cfgOff;
    logic inta;
    logic unimpl;
    logic write;
  } hwStrobe_t;

  function automatic logic [31:0] laneMask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] laneMerge(input logic [31:0] oldVal,
                                            input logic [31:0] newVal,
                                            input logic [3:0]  be);
    logic [31:0] m;
    m = laneMask(be);
    return (oldVal & ~m) | (newVal & m);
  endfunction

endpackage

// File: rtl/hostwin_ctrl.sv
module hostwin_ctrl
  import hostwin_pkg::*;
#(
  parameter int unsigned APER_W       = 24,
  parameter int unsigned IO_LIMIT     = 24'hC00000,
  parameter int unsigned CFG_ADDR_OFF = 24'hC00CF8,
  parameter int unsigned CFG_DATA_OFF = 24'hE00CFC,
  parameter int unsigned INTA_OFF     = 24'hF00000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [APER_W-3:0] reqDw,
  input  logic              cfgOn,
  input  logic              cfgSelf,
  input  logic              gpioMapped,
  input  logic [APER_W-3:0] gpioWinDw,
  output hwStrobe_t         stb
);
  localparam int unsigned DW_W = APER_W - 2;
  localparam logic [DW_W-1:0] IO_LIM_DW = DW_W'(IO_LIMIT >> 2);
  localparam logic [DW_W-1:0] CA_DW     = DW_W'(CFG_ADDR_OFF >> 2);
  localparam logic [DW_W-1:0] CD_DW     = DW_W'(CFG_DATA_OFF >> 2);
  localparam logic [DW_W-1:0] INTA_DW   = DW_W'(INTA_OFF >> 2);

  logic inIo, gpioHit, hitCa, hitCd, hitInta;

  always_comb begin
    inIo    = reqDw < IO_LIM_DW;
    gpioHit = inIo && gpioMapped && (reqDw == gpioWinDw);
    hitCa   = !inIo && (reqDw == CA_DW);
    hitCd   = !inIo && (reqDw == CD_DW);
    hitInta = !inIo && (reqDw == INTA_DW) && !reqWrite;

    stb        = '0;
    stb.write  = reqValid && reqWrite;
    stb.io     = reqValid && inIo && !gpioHit;
    stb.gpio   = reqValid && gpioHit;
    stb.cfgAddr = reqValid && hitCa;
    stb.cfgExt = reqValid && hitCd && cfgOn && !cfgSelf;
    stb.cfgInt = reqValid && hitCd && cfgOn && cfgSelf;
    stb.cfgOff = reqValid && hitCd && !cfgOn;
    stb.inta   = reqValid && hitInta;
    stb.unimpl = reqValid && !inIo && !hitCa && !hitCd && !hitInta;
  end

  // R2: never more than one destination per request
  p_one_dest_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.io, stb.gpio, stb.cfgAddr, stb.cfgExt, stb.cfgInt,
              stb.cfgOff, stb.inta, stb.unimpl}));

  // R2: the I/O window wins over all fixed register offsets
  p_io_priority_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && inIo) |-> !(stb.cfgAddr || stb.cfgExt || stb.cfgInt ||
                             stb.cfgOff || stb.inta || stb.unimpl));

endmodule

// File: rtl/hostwin_dpath.sv
module hostwin_dpath
  import hostwin_pkg::*;
#(
  parameter int unsigned APER_W    = 24,
  parameter int unsigned GPIO_SKEW = 32'h38,
  parameter logic [15:0] VENDOR_ID = 16'h10CC,
  parameter logic [15:0] DEVICE_ID = 16'h0660,
  parameter logic [31:0] CLASS_REV = 32'h06000000,
  parameter logic [31:0] MAP_KEY   = 32'h00000011
) (
  input  logic              clk,
  input  logic              rstN,
  input  hwStrobe_t         stb,
  input  logic [3:0]        reqBe,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       ioRdata,
  input  logic [31:0]       gpioRdata,
  input  logic [31:0]       cfgRdata,
  input  logic [7:0]        intaVector,
  output logic [31:0]       cfgAddrQ,
  output logic              cfgOn,
  output logic              cfgSelf,
  output logic              gpioMapped,
  output logic [APER_W-3:0] gpioWinDw,
  output logic              rspValid,
  output logic [31:0]       rspRdata
);
  localparam int unsigned DW_W = APER_W - 2;
  localparam logic [DW_W-1:0] SKEW_DW  = DW_W'(GPIO_SKEW >> 2);
  localparam logic [31:0]     BASE_MSK = ((32'd1 << APER_W) - 32'd1) & ~32'd3;
  localparam logic [5:0]      IDX_ID   = 6'd0;
  localparam logic [5:0]      IDX_CLS  = 6'd2;
  localparam logic [5:0]      IDX_BASE = 6'd16;
  localparam logic [5:0]      IDX_CTL  = 6'd17;

  logic [31:0] baseQ, ctlQ, localRd, rdNext, wrVal;
  logic [5:0]  regIdx;
  logic        anyReq, keyWrite;

  assign cfgOn   = cfgAddrQ[31];
  assign cfgSelf = (cfgAddrQ[23:8] == 16'h0);
  assign regIdx  = cfgAddrQ[7:2];
  assign wrVal   = reqWdata & laneMask(reqBe);
  assign anyReq  = stb.io | stb.gpio | stb.cfgAddr | stb.cfgExt | stb.cfgInt |
                   stb.cfgOff | stb.inta | stb.unimpl;
  assign keyWrite = stb.cfgInt && stb.write && (regIdx == IDX_CTL) &&
                    (wrVal == MAP_KEY);

  always_comb begin
    case (regIdx)
      IDX_ID:   localRd = {DEVICE_ID, VENDOR_ID};
      IDX_CLS:  localRd = CLASS_REV;
      IDX_BASE: localRd = baseQ;
      IDX_CTL:  localRd = ctlQ;
      default:  localRd = '0;
    endcase
  end

  always_comb begin
    if (stb.write)        rdNext = '0;
    else if (stb.io)      rdNext = ioRdata;
    else if (stb.gpio)    rdNext = gpioRdata;
    else if (stb.cfgAddr) rdNext = cfgAddrQ;
    else if (stb.cfgExt)  rdNext = cfgRdata;
    else if (stb.cfgInt)  rdNext = localRd;
    else if (stb.inta)    rdNext = {24'h0, intaVector};
    else                  rdNext = '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAddrQ   <= '0;
      baseQ      <= '0;
      ctlQ       <= '0;
      gpioMapped <= 1'b0;
      gpioWinDw  <= '0;
      rspValid   <= 1'b0;
      rspRdata   <= '0;
    end else begin
      rspValid <= anyReq;
      rspRdata <= rdNext;
      if (stb.cfgAddr && stb.write)
        cfgAddrQ <= laneMerge(cfgAddrQ, reqWdata, reqBe);
      if (stb.cfgInt && stb.write && regIdx == IDX_BASE)
        baseQ <= laneMerge(baseQ, reqWdata, reqBe) & BASE_MSK;
      if (stb.cfgInt && stb.write && regIdx == IDX_CTL)
        ctlQ <= laneMerge(ctlQ, reqWdata, reqBe);
      if (keyWrite) begin
        gpioMapped <= 1'b1;
        gpioWinDw  <= baseQ[APER_W-1:2] + SKEW_DW;
      end
    end
  end

  // R11: each request answered exactly one cycle later
  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> rspValid);
  p_no_spurious_rsp_r11: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> !rspValid);

  // R10: an armed window never disappears
  p_map_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    gpioMapped |=> gpioMapped);

  // R10: a non-key write to the enable register leaves the window alone
  p_nonkey_keeps_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cfgInt && stb.write && regIdx == IDX_CTL && wrVal != MAP_KEY)
      |=> ($stable(gpioWinDw) && $stable(gpioMapped)));

  // R5: disabled configuration writes change no host-function state
  p_cfg_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cfgOff && stb.write) |=> ($stable(baseQ) && $stable(ctlQ)));

  // R7: unimplemented writes leave the address register unchanged
  p_unimpl_wr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.unimpl && stb.write) |=> $stable(cfgAddrQ));

endmodule

// File: rtl/hostwin_decoder.sv
module hostwin_decoder
  import hostwin_pkg::*;
#(
  parameter int unsigned APER_W       = 24,
  parameter int unsigned IO_LIMIT     = 24'hC00000,
  parameter int unsigned CFG_ADDR_OFF = 24'hC00CF8,
  parameter int unsigned CFG_DATA_OFF = 24'hE00CFC,
  parameter int unsigned INTA_OFF     = 24'hF00000,
  parameter int unsigned GPIO_SKEW    = 32'h38
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [APER_W-1:0] reqAddr,
  input  logic [3:0]        reqBe,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              fwdWrite,
  output logic [3:0]        fwdBe,
  output logic [31:0]       fwdWdata,
  output logic              ioValid,
  output logic [APER_W-1:0] ioAddr,
  input  logic [31:0]       ioRdata,
  output logic              gpioValid,
  input  logic [31:0]       gpioRdata,
  output logic              cfgValid,
  output logic [31:0]       cfgAddr,
  input  logic [31:0]       cfgRdata,
  output logic              intaValid,
  input  logic [7:0]        intaVector
);
  hwStrobe_t         stb;
  logic              cfgOn, cfgSelf, gpioMapped;
  logic [APER_W-3:0] gpioWinDw;

  hostwin_ctrl #(
    .APER_W(APER_W), .IO_LIMIT(IO_LIMIT), .CFG_ADDR_OFF(CFG_ADDR_OFF),
    .CFG_DATA_OFF(CFG_DATA_OFF), .INTA_OFF(INTA_OFF)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqDw(reqAddr[APER_W-1:2]), .cfgOn(cfgOn), .cfgSelf(cfgSelf),
    .gpioMapped(gpioMapped), .gpioWinDw(gpioWinDw), .stb(stb)
  );

  hostwin_dpath #(
    .APER_W(APER_W), .GPIO_SKEW(GPIO_SKEW)
  ) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .reqBe(reqBe), .reqWdata(reqWdata),
    .ioRdata(ioRdata), .gpioRdata(gpioRdata), .cfgRdata(cfgRdata),
    .intaVector(intaVector), .cfgAddrQ(cfgAddr), .cfgOn(cfgOn),
    .cfgSelf(cfgSelf), .gpioMapped(gpioMapped), .gpioWinDw(gpioWinDw),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );

  assign fwdWrite  = reqWrite;
  assign fwdBe     = reqBe;
  assign fwdWdata  = reqWdata;
  assign ioAddr    = reqAddr;
  assign ioValid   = stb.io;
  assign gpioValid = stb.gpio;
  assign cfgValid  = stb.cfgExt;
  assign intaValid = stb.inta;

endmodule

// File: tb/tb_hostwin_decoder.sv
module tb_hostwin_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid, fwdWrite, ioValid, gpioValid, cfgValid, intaValid;
  logic [31:0] rspRdata, fwdWdata, cfgAddr, ioRdata, gpioRdata, cfgRdata;
  logic [3:0]  fwdBe;
  logic [23:0] ioAddr;
  logic [7:0]  intaVector = 8'h5C;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  // Simple responders for the forwarded ports
  assign ioRdata   = {8'hA5, ioAddr};
  assign gpioRdata = 32'h6B6B0000 | {28'h0, fwdBe};
  assign cfgRdata  = ~cfgAddr;

  hostwin_decoder dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .fwdWrite(fwdWrite),
    .fwdBe(fwdBe), .fwdWdata(fwdWdata), .ioValid(ioValid), .ioAddr(ioAddr),
    .ioRdata(ioRdata), .gpioValid(gpioValid), .gpioRdata(gpioRdata),
    .cfgValid(cfgValid), .cfgAddr(cfgAddr), .cfgRdata(cfgRdata),
    .intaValid(intaValid), .intaVector(intaVector)
  );

  // strobes seen during the request cycle, and the response after it
  logic [3:0]  seen;     // {io, gpio, cfg, inta}
  logic [23:0] seenIoAddr;
  logic [3:0]  seenBe;
  logic [31:0] seenWd;
  logic        gotRsp;
  logic [31:0] gotRd;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [23:0] a, input logic [3:0] be,
                     input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqBe = be; reqWdata = wd;
    #2;
    seen = {ioValid, gpioValid, cfgValid, intaValid};
    seenIoAddr = ioAddr; seenBe = fwdBe; seenWd = fwdWdata;
    @(posedge clk);
    #2;
    gotRsp = rspValid; gotRd = rspRdata;
    reqValid = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a);
    acc(1'b0, a, 4'hF, 32'h0);
  endtask

  task automatic wr(input logic [23:0] a, input logic [3:0] be, input logic [31:0] d);
    acc(1'b1, a, be, d);
  endtask

  localparam logic [23:0] CA = 24'hC00CF8, CD = 24'hE00CFC, IA = 24'hF00000;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk("R1 rspValid idle", {31'h0, rspValid}, 32'h0);
    rd(CA);
    chk("R1 cfg addr after reset", gotRd, 32'h0);
    rd(24'h000038);
    chk("R1 no gpio at reset (strobes)", {28'h0, seen}, 32'h8);

    // R2 + R7 + R6: sweep the aperture in 256 KB steps
    for (int i = 0; i < 64; i++) begin
      logic [23:0] a;
      a = 24'(i) << 18;
      rd(a);
      if (a < 24'hC00000) begin
        chk("R2 sweep strobes", {28'h0, seen}, 32'h8);
        chk("R2 sweep ioAddr", {8'h0, seenIoAddr}, {8'h0, a});
        chk("R2 sweep data", gotRd, {8'hA5, a});
      end else if (a == IA) begin
        chk("R6 sweep inta strobe", {28'h0, seen}, 32'h1);
        chk("R6 sweep vector", gotRd, 32'h0000005C);
      end else begin
        chk("R7 sweep strobes", {28'h0, seen}, 32'h0);
        chk("R7 sweep data", gotRd, 32'hFFFFFFFF);
      end
      chk("R11 sweep rsp", {31'h0, gotRsp}, 32'h1);
    end

    // R2: top edge of the I/O window and a write
    rd(24'hBFFFFC);
    chk("R2 top io data", gotRd, 32'hA5BFFFFC);
    wr(24'h001236, 4'b0100, 32'h00EE0000);
    chk("R2 io write strobes", {28'h0, seen}, 32'h8);
    chk("R2 io write be", {28'h0, seenBe}, 32'h4);
    chk("R11 write rsp data zero", gotRd, 32'h0);

    // R3: byte-lane writes to the address register
    wr(CA, 4'b0011, 32'hFFFFFFFF);
    rd(CA);
    chk("R3 low lanes", gotRd, 32'h0000FFFF);
    wr(CA, 4'b1100, 32'h80000000);
    rd(CA);
    chk("R3 high lanes", gotRd, 32'h8000FFFF);

    // R5: disabled configuration access
    wr(CA, 4'hF, 32'h00000040);
    rd(CD);
    chk("R5 disabled read", gotRd, 32'hFFFFFFFF);
    chk("R5 disabled no cfgValid", {28'h0, seen}, 32'h0);
    wr(CD, 4'hF, 32'h00ABCD00);
    chk("R5 disabled write no port", {28'h0, seen}, 32'h0);
    wr(CA, 4'hF, 32'h80000040);
    rd(CD);
    chk("R5 base untouched by disabled write", gotRd, 32'h0);

    // R4: forwarded configuration data with lane select
    wr(CA, 4'hF, 32'h80000800);
    rd(CD);
    chk("R4 fwd read strobe", {28'h0, seen}, 32'h2);
    chk("R4 fwd read data", gotRd, 32'h7FFFF7FF);
    wr(24'hE00CFE, 4'b0100, 32'h00AB0000);
    chk("R4 fwd write strobe", {28'h0, seen}, 32'h2);
    chk("R4 fwd write be", {28'h0, seenBe}, 32'h4);
    chk("R4 fwd write data", seenWd, 32'h00AB0000);
    chk("R4 cfgAddr port", cfgAddr, 32'h80000800);

    // R8: host function identity
    wr(CA, 4'hF, 32'h80000000);
    rd(CD);
    chk("R8 id register", gotRd, 32'h066010CC);
    chk("R8 not forwarded", {28'h0, seen}, 32'h0);
    wr(CA, 4'hF, 32'h80000008);
    rd(CD);
    chk("R8 class register", gotRd, 32'h06000000);
    wr(CA, 4'hF, 32'h8000004C);
    rd(CD);
    chk("R8 unlisted reads zero", gotRd, 32'h0);

    // R9: base register masking
    wr(CA, 4'hF, 32'h80000040);
    wr(CD, 4'hF, 32'hFF123457);
    rd(CD);
    chk("R9 base masked", gotRd, 32'h00123454);

    // R10: mapping needs the exact key
    rd(24'h12348C);
    chk("R10 unmapped goes to io", {28'h0, seen}, 32'h8);
    wr(CA, 4'hF, 32'h80000044);
    wr(CD, 4'hF, 32'h00000012);
    rd(24'h12348C);
    chk("R10 non-key leaves unmapped", {28'h0, seen}, 32'h8);
    wr(CD, 4'hF, 32'h00000011);
    rd(24'h12348C);
    chk("R10 mapped strobe", {28'h0, seen}, 32'h4);
    chk("R10 gpio data", gotRd, 32'h6B6B000F);
    rd(24'h123488);
    chk("R10 neighbour below is io", {28'h0, seen}, 32'h8);
    rd(24'h123490);
    chk("R10 neighbour above is io", {28'h0, seen}, 32'h8);

    // R10: base change alone does not move the window
    wr(CA, 4'hF, 32'h80000040);
    wr(CD, 4'hF, 32'h00002000);
    rd(24'h12348C);
    chk("R10 window stays after base write", {28'h0, seen}, 32'h4);
    rd(24'h002038);
    chk("R10 new spot not yet mapped", {28'h0, seen}, 32'h8);
    wr(CA, 4'hF, 32'h80000044);
    wr(CD, 4'hF, 32'h00000011);
    rd(24'h002038);
    chk("R10 remapped strobe", {28'h0, seen}, 32'h4);
    rd(24'h12348C);
    chk("R10 old spot back to io", {28'h0, seen}, 32'h8);

    // R6 / R7: writes to acknowledge and unimplemented offsets
    wr(IA, 4'hF, 32'h12345678);
    chk("R6 inta write no strobe", {28'h0, seen}, 32'h0);
    wr(24'hD00000, 4'hF, 32'h0);
    chk("R7 unimpl write no strobe", {28'h0, seen}, 32'h0);
    rd(CA);
    chk("R7 address reg unchanged", gotRd, 32'h80000044);
    rd(24'hC00CFC);
    chk("R7 gap read", gotRd, 32'hFFFFFFFF);

    // R11: idle cycle yields no response
    @(negedge clk); @(negedge clk);
    chk("R11 idle no rsp", {31'h0, rspValid}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule